// File: doc/BRIEF.md
# Triggered Capture Logic Analyzer Core

This core records a parallel signal bus into an on-chip ring of samples so that a host can later inspect what happened around an event of interest. Once armed by the host, it stores one sample on every clock into a circular buffer. A write slot advances and wraps. A separate trigger bus, often wired to the low bits of the sampled data, is compared against a programmable value. A per-bit mask selects which bits take part in the comparison. When the trigger fires, the core keeps recording for half a buffer more and then stops. It records the slot at which it stopped, which is where the oldest stored sample sits.

The host reaches everything through a 32-bit single-cycle Wishbone slave. The lower part of the word address space reads the buffer as packed words, with several samples per word. Four 32-bit registers follow directly after the sample words. In order, they are the status, the stop slot, the trigger value and the trigger mask. To unroll the capture, the host reads the stop slot and walks the buffer upward from it, wrapping at the end.

Top module: `lan_core`

## Requirements
- R1: Sample slot s lives in bus word s / L at lane s % L, where L = 32 / DATA_WIDTH. Lane j occupies bits [j*DATA_WIDTH +: DATA_WIDTH], so the earlier slot sits in the lower bits.
- R2: The registers sit at word addresses W, W+1, W+2 and W+3, where W = 2^ADDR_WIDTH / L. They are, in that order, status, stop slot, trigger value and trigger mask. Status reads {24'b0, running, done, 6'b0}. Value and mask bits above TRIG_WIDTH read as zero.
- R3: A status write with bit 7 set, while stopped, sets running, clears done and restarts the write slot at 0. The first sample is stored on the clock after the write, and one sample is stored each clock after that. Status writes with bit 7 clear, or made while running, are ignored.
- R4: While running and not yet triggered, the trigger fires on the first stored sample whose trigger bits equal the value at every bit with mask 1. A mask of all zeros fires on the first stored sample.
- R5: After the trigger sample, exactly 2^(ADDR_WIDTH-1) further samples are stored. Then running clears and done sets, never both at once, and the buffer no longer changes.
- R6: The stop slot equals (trigger slot + 2^(ADDR_WIDTH-1) + 1) mod 2^ADDR_WIDTH, which is the oldest sample. It changes only when a capture finishes.
- R7: Every bus access (cyc and stb high) is acknowledged for exactly one clock, starting one clock after stb rises. Read data is valid with the acknowledge.
- R8: Writes to the sample words leave the buffer unchanged.
- R9: Writes to the trigger value or mask while running are acknowledged but have no effect.
- R10: After reset, all four registers read zero and the core is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | DATA_WIDTH | Bus being recorded |
| trig_i | input | TRIG_WIDTH | Bits compared for the trigger |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | WORD_AW+1 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |

## Verification
The assertions assume a host that holds cyc and stb until it sees the acknowledge and then drops stb for at least one clock. They also assume a host that arms the core only through the status register. The bench issues every access as a one-clock strobe followed by an idle clock, so the one-clock acknowledge pulse is never confused with back-to-back requests. The sampled bus is a free-running counter changed on the falling edge. The trigger bus is its low byte, so the expected trigger slot, stop slot and every buffer word follow arithmetically from the value seen at the arming edge.

// File: rtl/lan_pkg.sv
package lan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_POST} lan_state_e;
  localparam int BUS_W = 32;
  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_STOP   = 2'd1;
  localparam logic [1:0] REG_TVAL   = 2'd2;
  localparam logic [1:0] REG_TCARE  = 2'd3;
endpackage

// File: rtl/lan_trig_match.sv
module lan_trig_match #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] trig_i,
  input  logic [TW-1:0] value_i,
  input  logic [TW-1:0] care_i,
  output logic          hit_o
);
  // a bit only counts when its mask bit is set
  assign hit_o = ~|((trig_i ^ value_i) & care_i);
endmodule

// File: rtl/lan_sample_buf.sv
module lan_sample_buf #(
  parameter int DW = 16,
  parameter int AW = 5,
  localparam int LANES = 32 / DW,
  localparam int LSB_W = $clog2(LANES),
  localparam int WAW   = AW - LSB_W,
  localparam int WORDS = 2 ** WAW
) (
  input  logic           clk,
  input  logic           we_i,
  input  logic [AW-1:0]  slot_i,
  input  logic [DW-1:0]  din_i,
  input  logic [WAW-1:0] rd_word_i,
  output logic [31:0]    dout_o
);
  logic [AW-1:0]  row_full;
  logic [WAW-1:0] row;
  assign row_full = slot_i >> LSB_W;
  assign row      = row_full[WAW-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] mem [WORDS];
    logic          lane_we;
    assign lane_we = we_i && ((32'(slot_i) % LANES) == l);
    always_ff @(posedge clk) begin
      if (lane_we) mem[row] <= din_i;
    end
    assign dout_o[l*DW +: DW] = mem[rd_word_i];
  end
endmodule

// File: rtl/lan_ctrl.sv
module lan_ctrl
  import lan_pkg::*;
#(
  parameter int AW = 5,
  localparam int PW = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          hit_i,
  output logic          running_o,
  output logic          done_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_slot_o,
  output logic [AW-1:0] stop_cnt_o
);
  lan_state_e    st_q, st_n;
  logic [AW-1:0] ptr_q, ptr_n, stop_q, stop_n;
  logic [PW-1:0] post_q, post_n;
  logic          done_q, done_n;

  always_comb begin
    st_n    = st_q;
    ptr_n   = ptr_q;
    post_n  = post_q;
    done_n  = done_q;
    stop_n  = stop_q;
    wr_en_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (arm_i) begin
          st_n   = ST_ARMED;
          ptr_n  = '0;
          done_n = 1'b0;
        end
      end
      ST_ARMED: begin
        wr_en_o = 1'b1;
        ptr_n   = ptr_q + 1'b1;
        if (hit_i) begin
          st_n   = ST_POST;
          post_n = '0;
        end
      end
      ST_POST: begin
        wr_en_o = 1'b1;
        ptr_n   = ptr_q + 1'b1;
        post_n  = post_q + 1'b1;
        if (&post_q) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          stop_n = ptr_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      post_q <= '0;
      done_q <= 1'b0;
      stop_q <= '0;
    end else begin
      st_q   <= st_n;
      ptr_q  <= ptr_n;
      post_q <= post_n;
      done_q <= done_n;
      stop_q <= stop_n;
    end
  end

  assign running_o  = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign wr_slot_o  = ptr_q;
  assign stop_cnt_o = stop_q;
endmodule

// File: rtl/lan_core.sv
module lan_core
  import lan_pkg::*;
#(
  parameter int DATA_WIDTH = 16,
  parameter int ADDR_WIDTH = 5,
  parameter int TRIG_WIDTH = 8,
  localparam int LANES   = 32 / DATA_WIDTH,
  localparam int LSB_W   = $clog2(LANES),
  localparam int WORD_AW = ADDR_WIDTH - LSB_W,
  localparam int WORDS   = 2 ** WORD_AW,
  localparam int BUS_AW  = WORD_AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_WIDTH-1:0] sample_i,
  input  logic [TRIG_WIDTH-1:0] trig_i,
  input  logic                  wb_cyc_i,
  input  logic                  wb_stb_i,
  input  logic                  wb_we_i,
  input  logic [BUS_AW-1:0]     wb_adr_i,
  input  logic [BUS_W-1:0]      wb_dat_i,
  output logic [BUS_W-1:0]      wb_dat_o,
  output logic                  wb_ack_o
);
  logic                  ack_q;
  logic [BUS_W-1:0]      dat_q, rd_n;
  logic [TRIG_WIDTH-1:0] trig_val_q, trig_care_q;
  logic                  acc, wr, in_regs, in_smp, arm, hit;
  logic                  tval_en, tcare_en, running, done, wr_en;
  logic [BUS_AW-1:0]     reg_off;
  logic [1:0]            reg_idx;
  logic [ADDR_WIDTH-1:0] wr_slot, stop_cnt;
  logic [BUS_W-1:0]      buf_word;

  // bus decode
  assign acc     = wb_cyc_i && wb_stb_i && !ack_q;
  assign wr      = acc && wb_we_i;
  assign in_smp  = (wb_adr_i < BUS_AW'(WORDS));
  assign reg_off = wb_adr_i - BUS_AW'(WORDS);
  assign in_regs = !in_smp && (reg_off < BUS_AW'(4));
  assign reg_idx = reg_off[1:0];
  assign arm      = wr && in_regs && (reg_idx == REG_STATUS) && wb_dat_i[7] && !running;
  assign tval_en  = wr && in_regs && (reg_idx == REG_TVAL)  && !running;
  assign tcare_en = wr && in_regs && (reg_idx == REG_TCARE) && !running;

  lan_trig_match #(.TW(TRIG_WIDTH)) u_match (
    .trig_i (trig_i),
    .value_i(trig_val_q),
    .care_i (trig_care_q),
    .hit_o  (hit)
  );

  lan_ctrl #(.AW(ADDR_WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm),
    .hit_i     (hit),
    .running_o (running),
    .done_o    (done),
    .wr_en_o   (wr_en),
    .wr_slot_o (wr_slot),
    .stop_cnt_o(stop_cnt)
  );

  lan_sample_buf #(.DW(DATA_WIDTH), .AW(ADDR_WIDTH)) u_buf (
    .clk      (clk),
    .we_i     (wr_en),
    .slot_i   (wr_slot),
    .din_i    (sample_i),
    .rd_word_i(wb_adr_i[WORD_AW-1:0]),
    .dout_o   (buf_word)
  );

  // read mux
  always_comb begin
    rd_n = '0;
    if (in_smp) begin
      rd_n = buf_word;
    end else if (in_regs) begin
      case (reg_idx)
        REG_STATUS: rd_n = {24'd0, running, done, 6'd0};
        REG_STOP:   rd_n = BUS_W'(stop_cnt);
        REG_TVAL:   rd_n = BUS_W'(trig_val_q);
        default:    rd_n = BUS_W'(trig_care_q);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q       <= 1'b0;
      dat_q       <= '0;
      trig_val_q  <= '0;
      trig_care_q <= '0;
    end else begin
      ack_q <= acc;
      if (acc)      dat_q       <= rd_n;
      if (tval_en)  trig_val_q  <= wb_dat_i[TRIG_WIDTH-1:0];
      if (tcare_en) trig_care_q <= wb_dat_i[TRIG_WIDTH-1:0];
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;
endmodule

// File: rtl/lan_core_chk.sv
module lan_core_chk #(
  parameter int AW = 5,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wb_cyc_i,
  input logic          wb_stb_i,
  input logic          wb_ack_o,
  input logic          running,
  input logic          done,
  input logic [AW-1:0] stop_cnt,
  input logic [AW-1:0] wr_slot,
  input logic [TW-1:0] trig_val_q,
  input logic [TW-1:0] trig_care_q
);
  p_ack_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o);

  p_run_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && done));

  p_done_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> done);

  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running) |-> (wr_slot == AW'($past(wr_slot) + 1'b1)));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(running) |-> $stable(stop_cnt));

  p_trig_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running) |-> ($stable(trig_val_q) && $stable(trig_care_q)));
endmodule

bind lan_core lan_core_chk #(.AW(ADDR_WIDTH), .TW(TRIG_WIDTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wb_cyc_i   (wb_cyc_i),
  .wb_stb_i   (wb_stb_i),
  .wb_ack_o   (wb_ack_o),
  .running    (running),
  .done       (done),
  .stop_cnt   (stop_cnt),
  .wr_slot    (wr_slot),
  .trig_val_q (trig_val_q),
  .trig_care_q(trig_care_q)
);

// File: tb/lan_core_tb_top.sv
`timescale 1ns/1ps
module lan_core_tb_top;
  localparam int DW = 16, AW = 5, TW = 8;
  localparam int DEPTH = 2 ** AW, HALF = DEPTH / 2, LANES = 32 / DW;
  localparam int WORDS = DEPTH / LANES, BAW = $clog2(WORDS) + 1;
  localparam int A_ST = WORDS, A_SC = WORDS + 1, A_TV = WORDS + 2, A_TC = WORDS + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] smp = '0;
  logic cyc = 0, stb = 0, we = 0;
  logic [BAW-1:0] adr = '0;
  logic [31:0] wdat = '0, rdat;
  logic ack;
  int total = 0, bad = 0;
  logic [DW-1:0] edge_smp;
  logic ack_seen, ack_gone;
  bit finished = 0;

  always #5 clk = ~clk;

  lan_core #(.DATA_WIDTH(DW), .ADDR_WIDTH(AW), .TRIG_WIDTH(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(smp), .trig_i(smp[TW-1:0]),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack));

  initial forever begin
    @(negedge clk);
    smp = smp + 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input bit w, input int a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = BAW'(a); wdat = d;
    @(posedge clk);
    #1;
    edge_smp = smp;
    ack_seen = ack;
    q = rdat;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0;
    @(posedge clk);
    #1;
    ack_gone = !ack;
  endtask

  task automatic wr(int a, logic [31:0] d);
    logic [31:0] q;
    bus(1, a, d, q);
  endtask

  task automatic rd(int a, output logic [31:0] q);
    bus(0, a, 32'd0, q);
  endtask

  task automatic wait_done();
    logic [31:0] q;
    for (int i = 0; i < 2000; i++) begin
      rd(A_ST, q);
      if (q[6]) break;
    end
  endtask

  // first k >= 0 where sample v0+k matches under mask
  function automatic int find_k(logic [DW-1:0] v0, logic [7:0] tv, logic [7:0] tc);
    for (int k = 0; k < 256; k++) begin
      logic [DW-1:0] v;
      v = v0 + DW'(k);
      if (((v[7:0] ^ tv) & tc) == 8'd0) return k;
    end
    return -1;
  endfunction

  // checks stop slot and the samples from trigger to end
  task automatic check_capture(string tag, logic [DW-1:0] v0, int k);
    logic [31:0] q, sc;
    logic [DW-1:0] slots [DEPTH];
    int n;
    n = k + HALF + 1;
    rd(A_SC, sc);
    check({tag, " R6 stop slot"}, sc, 32'((k + HALF + 1) % DEPTH));
    for (int w = 0; w < WORDS; w++) begin
      rd(w, q);
      for (int l = 0; l < LANES; l++) slots[w*LANES + l] = q[l*DW +: DW];
    end
    for (int i = DEPTH - 1 - HALF; i < DEPTH; i++) begin
      check({tag, " R5 ordered sample"}, 32'(slots[(sc + i) % DEPTH]),
            32'(DW'(v0 + DW'(n - DEPTH + i))));
    end
  endtask

  task automatic t_reset();
    logic [31:0] q;
    rd(A_ST, q);
    check("R10 status", q, 0);
    check("R7 ack one clock after strobe", 32'(ack_seen), 1);
    check("R7 ack one clock long", 32'(ack_gone), 1);
    rd(A_SC, q); check("R10 stop slot", q, 0);
    rd(A_TV, q); check("R10 trigger value", q, 0);
    rd(A_TC, q); check("R10 trigger mask", q, 0);
  endtask

  task automatic t_regs();
    logic [31:0] q;
    wr(A_TV, 32'hFFFF_FFFF); rd(A_TV, q); check("R2 value width", q, 32'h0000_00FF);
    wr(A_TC, 32'h1234_5678); rd(A_TC, q); check("R2 mask width", q, 32'h0000_0078);
  endtask

  task automatic t_full();
    logic [31:0] q, w0, w1;
    logic [7:0] tv;
    logic [DW-1:0] v0;
    int k, n;
    tv = smp[7:0] + 8'd100;
    wr(A_TV, 32'(tv));
    wr(A_TC, 32'hFF);
    wr(A_ST, 32'h80);
    v0 = edge_smp + 1'b1;
    k = find_k(v0, tv, 8'hFF);
    rd(A_ST, q); check("R3 running after arm", q, 32'h80);
    wr(A_ST, 32'h80);          // re-arm while running: ignored
    wr(A_TV, 32'h0);           // locked while running
    wr(A_TC, 32'h0);
    wait_done();
    rd(A_ST, q); check("R5 status after stop", q, 32'h40);
    rd(A_TV, q); check("R9 value kept", q, 32'(tv));
    rd(A_TC, q); check("R9 mask kept", q, 32'hFF);
    check_capture("full", v0, k);
    // whole buffer packing: slot s holds last m < n with m % DEPTH == s
    n = k + HALF + 1;
    for (int w = 0; w < WORDS; w++) begin
      logic [31:0] exp;
      for (int l = 0; l < LANES; l++) begin
        int s, m;
        s = w * LANES + l;
        m = s + DEPTH * ((n - 1 - s) / DEPTH);
        exp[l*DW +: DW] = v0 + DW'(m);
      end
      rd(w, q);
      check("R1 packed word", q, exp);
    end
    rd(0, w0);
    repeat (10) @(posedge clk);
    rd(0, w1);
    check("R5 buffer frozen after stop", w1, w0);
    check("R4 trigger sample matched", 32'(DW'(v0 + DW'(k)) & 8'hFF), 32'(tv));
  endtask

  task automatic t_ignored_writes();
    logic [31:0] q0, q;
    rd(3, q0);
    wr(3, 32'hDEAD_BEEF);
    rd(3, q); check("R8 sample write ignored", q, q0);
    wr(A_ST, 32'hFFFF_FF3F);
    rd(A_ST, q); check("R3 status write without bit 7 ignored", q, 32'h40);
  endtask

  task automatic t_mask();
    logic [31:0] q;
    logic [DW-1:0] v0;
    int k;
    wr(A_TV, 32'h05);
    wr(A_TC, 32'h0F);
    wr(A_ST, 32'h80);
    v0 = edge_smp + 1'b1;
    k = find_k(v0, 8'h05, 8'h0F);
    wait_done();
    rd(A_ST, q); check("R4 masked run finished", q, 32'h40);
    check("R4 masked trigger low nibble", 32'(DW'(v0 + DW'(k)) & 4'hF), 32'h5);
    check_capture("mask R4", v0, k);
  endtask

  task automatic t_care_zero();
    logic [DW-1:0] v0;
    wr(A_TC, 32'h0);
    wr(A_ST, 32'h80);
    v0 = edge_smp + 1'b1;
    wait_done();
    check_capture("zero mask R4", v0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_full();
    t_ignored_writes();
    t_mask();
    t_care_zero();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule